// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel stereo sample pairs into a single MSB-first serial data stream. An external bit clock and word clock set the timing. Both arrive as ordinary inputs and are sampled by the system clock. Each edge of the bit clock is detected in that domain, and the serial output register is updated on the system clock edge that first sees the selected launch edge. A receiver samples the data on the opposite bit-clock edge.

Five framings are supported, chosen by a 3-bit format code:
- Left-justified, right-justified and I2S treat the word clock as a channel-select level.
- The two DSP framings treat the rising word-clock edge as a frame sync. The left word follows that edge, and the right word follows the left word with no gap.

A one-entry holding register accepts the next sample pair through a valid/ready handshake. If no fresh pair is present when a frame starts, the previous pair is sent again and a sticky underrun flag is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: The serial output changes only on the system clock edge that observes a launch edge of the bit clock. The launch edge is the falling edge when `cfg_bclk_inv`=0 and the rising edge when `cfg_bclk_inv`=1. Between launch edges the output holds its value.
- R2: Words are sent MSB first. `cfg_wlen` sets the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Only the low word-length bits of each sample input are sent, and higher bits are ignored.
- R3: Left-justified mode (`cfg_fmt`=0): a high word clock marks the left channel. The MSB goes out in the slot where the word clock changes level.
- R4: I2S mode (`cfg_fmt`=2): a low word clock marks the left channel. The MSB goes out one slot after the level change. With a half-frame equal to the word length, the LSB falls in the first slot of the following half.
- R5: Right-justified mode (`cfg_fmt`=1): a high word clock marks the left channel. The LSB occupies the last slot of each half, and the half length is measured from the previous half. With a 32-bit word this mode is rejected: the output stays low and no held sample is consumed.
- R6: DSP A mode (`cfg_fmt`=3): a rising word-clock edge starts a frame. The left MSB goes out one slot later, and the right word follows the left LSB directly. A frame may be as short as twice the word length.
- R7: DSP B mode (`cfg_fmt`=4): the left MSB goes out in the same slot as the rising word-clock edge. The right word follows directly. A high level lasting longer than one slot does not start another frame.
- R8: Every slot that carries no word bit drives the output low.
- R9: `smp_ready` is high while the holding register is empty. A pair offered with `smp_valid` is captured, and `smp_ready` then stays low until the next left-word start takes the pair.
- R10: When a left word starts with the holding register empty, the previous pair is sent again and `underrun_o` is set. The flag stays set until reset.
- R11: During and just after reset, `sdata_o` and `underrun_o` are low and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Framing: 0 LJ, 1 RJ, 2 I2S, 3 DSP A, 4 DSP B |
| cfg_wlen | input | 2 | Word length code: 16/20/24/32 bits |
| cfg_bclk_inv | input | 1 | 0: data launched on falling bit-clock edge; 1: on rising |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock or frame sync |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| sdata_o | output | 1 | Serial data out |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
Two cases are the hardest to reach from the ports. The first is a word that spills across a frame boundary: the I2S LSB or the DSP A right-word LSB landing in slot 0 of the next frame, at the minimum frame length. The second is an underrun in the middle of a stream. The bench drives every bit-clock and word-clock edge itself from a per-slot table. It runs the I2S and DSP A segments with the half-frame equal to the word length, and adds trailing slots after the last frame so the spilled bit is observed. For underruns it withholds the mid-frame push in a chosen frame, so the next left start finds the holding register empty and the bench can predict the repeated pair and the exact slot where the flag rises.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

  localparam int SMP_W = 32;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  // word length in bits from the 2-bit code
  function automatic logic [5:0] wl_bits(input logic [1:0] code);
    logic [5:0] r;
    case (code)
      2'd0:    r = 6'd16;
      2'd1:    r = 6'd20;
      2'd2:    r = 6'd24;
      default: r = 6'd32;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/aud_tx_slot_ctrl.sv
`timescale 1ns/1ps
module aud_tx_slot_ctrl
  import aud_tx_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  fmt_e       fmt,
  input  logic [5:0] wl,
  input  logic       bclk_inv,
  input  logic       bclk_i,
  input  logic       wclk_i,
  output logic       launch,
  output logic       load_l,
  output logic       load_r
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bclk_q;
  logic             wclk_q, wclk_d;
  logic             fresh_q;
  logic [CNT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             pend_q, pend_d;
  logic             pend_left_q, pend_left_d;
  logic [5:0]       rcnt_q, rcnt_d;

  logic             chg, rise;
  logic [CNT_W-1:0] slot_inc, wl_c;
  logic             rj_hit;
  logic             ld_l, ld_r, is_dsp;

  // edge detection of the external clocks
  always_comb begin
    launch   = bclk_inv ? (bclk_i & ~bclk_q) : (~bclk_i & bclk_q);
    chg      = wclk_i ^ wclk_q;
    rise     = wclk_i & ~wclk_q;
    slot_inc = (slot_q == CNT_MAX) ? slot_q : slot_q + 1'b1;
    wl_c     = CNT_W'(wl);
    is_dsp   = (fmt == FMT_DSPA) || (fmt == FMT_DSPB);
  end

  // slot position and measured half-frame length
  always_comb begin
    slot_d = (chg || fresh_q) ? '0 : slot_inc;
    if (chg) half_d = fresh_q ? '0 : slot_inc;
    else     half_d = half_q;
    wclk_d = wclk_i;
    rj_hit = (wl != 6'd32) && (half_d >= wl_c) && (slot_d == half_d - wl_c);
  end

  // word start decisions per framing
  always_comb begin
    ld_l        = 1'b0;
    ld_r        = 1'b0;
    pend_d      = 1'b0;
    pend_left_d = pend_left_q;
    case (fmt)
      FMT_LJ: begin
        ld_l = chg & wclk_i;
        ld_r = chg & ~wclk_i;
      end
      FMT_RJ: begin
        ld_l = rj_hit & wclk_i;
        ld_r = rj_hit & ~wclk_i;
      end
      FMT_I2S: begin
        ld_l        = pend_q & pend_left_q;
        ld_r        = pend_q & ~pend_left_q;
        pend_d      = chg;
        pend_left_d = ~wclk_i;
      end
      FMT_DSPA: begin
        ld_l        = pend_q;
        ld_r        = (rcnt_q == 6'd1);
        pend_d      = rise;
        pend_left_d = 1'b1;
      end
      FMT_DSPB: begin
        ld_l = rise;
        ld_r = (rcnt_q == 6'd1);
      end
      default: begin
        ld_l = 1'b0;
        ld_r = 1'b0;
      end
    endcase
    load_l = launch & ld_l;
    load_r = launch & ld_r;
  end

  // countdown from the left start to the right start in DSP framings
  always_comb begin
    if (ld_l && is_dsp)      rcnt_d = wl;
    else if (rcnt_q != 6'd0) rcnt_d = rcnt_q - 6'd1;
    else                     rcnt_d = rcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q      <= 1'b0;
      fresh_q     <= 1'b1;
      slot_q      <= '0;
      half_q      <= '0;
      pend_q      <= 1'b0;
      pend_left_q <= 1'b0;
      rcnt_q      <= '0;
    end else if (launch) begin
      wclk_q      <= wclk_d;
      fresh_q     <= 1'b0;
      slot_q      <= slot_d;
      half_q      <= half_d;
      pend_q      <= pend_d;
      pend_left_q <= pend_left_d;
      rcnt_q      <= rcnt_d;
    end
  end

  AST_ONE_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_l, load_r})); // R6

  AST_DSP_NO_DOUBLE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dsp && load_l) |=> !load_l); // R7

endmodule

// File: rtl/aud_tx_sample_buf.sv
`timescale 1ns/1ps
module aud_tx_sample_buf
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             smp_ready,
  input  logic             load_l,
  input  logic             load_r,
  output logic [SMP_W-1:0] word_o,
  output logic             underrun_o
);

  logic             full_q, full_d;
  logic [SMP_W-1:0] hold_l_q, hold_r_q;
  logic [SMP_W-1:0] cur_l_q, cur_r_q;
  logic             ur_q, ur_d;
  logic             accept, take;

  always_comb begin
    smp_ready  = ~full_q;
    accept     = smp_valid & ~full_q;
    take       = load_l & full_q;
    underrun_o = ur_q;
    if (load_l)      word_o = full_q ? hold_l_q : cur_l_q;
    else if (load_r) word_o = cur_r_q;
    else             word_o = '0;
  end

  always_comb begin
    if (accept)      full_d = 1'b1;
    else if (load_l) full_d = 1'b0;
    else             full_d = full_q;
    ur_d = ur_q | (load_l & ~full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      ur_q   <= ur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (accept) begin
      hold_l_q <= smp_left;
      hold_r_q <= smp_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l_q <= '0;
      cur_r_q <= '0;
    end else if (take) begin
      cur_l_q <= hold_l_q;
      cur_r_q <= hold_r_q;
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o); // R10

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready); // R9

  AST_HELD_UNTIL_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !load_l) |=> !smp_ready); // R9

endmodule

// File: rtl/aud_tx_shifter.sv
`timescale 1ns/1ps
module aud_tx_shifter
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             load,
  input  logic [5:0]       wl,
  input  logic [SMP_W-1:0] word,
  output logic             sdata_o
);

  logic [SMP_W-1:0] sr_q, sr_d, aligned;
  logic             sd_q, sd_d;

  always_comb begin
    aligned = word << (6'd32 - wl);
    if (load) begin
      sd_d = aligned[SMP_W-1];
      sr_d = aligned << 1;
    end else begin
      sd_d = sr_q[SMP_W-1];
      sr_d = sr_q << 1;
    end
    sdata_o = sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sd_q <= 1'b0;
    end else if (launch) begin
      sr_q <= sr_d;
      sd_q <= sd_d;
    end
  end

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdata_o)); // R1

endmodule

// File: rtl/aud_serial_tx.sv
`timescale 1ns/1ps
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_fmt,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_bclk_inv,
  input  logic        bclk_i,
  input  logic        wclk_i,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [31:0] smp_left,
  input  logic [31:0] smp_right,
  output logic        sdata_o,
  output logic        underrun_o
);

  fmt_e             fmt;
  logic [5:0]       wl;
  logic             launch, load_l, load_r, load_any;
  logic [SMP_W-1:0] word;

  always_comb begin
    fmt      = fmt_e'(cfg_fmt);
    wl       = wl_bits(cfg_wlen);
    load_any = load_l | load_r;
  end

  aud_tx_slot_ctrl #(.CNT_W(CNT_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .wl       (wl),
    .bclk_inv (cfg_bclk_inv),
    .bclk_i   (bclk_i),
    .wclk_i   (wclk_i),
    .launch   (launch),
    .load_l   (load_l),
    .load_r   (load_r)
  );

  aud_tx_sample_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .smp_ready  (smp_ready),
    .load_l     (load_l),
    .load_r     (load_r),
    .word_o     (word),
    .underrun_o (underrun_o)
  );

  aud_tx_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .load    (load_any),
    .wl      (wl),
    .word    (word),
    .sdata_o (sdata_o)
  );

  AST_RJ32_NO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt == 3'd1 && cfg_wlen == 2'd3) |-> !load_any); // R5

endmodule

// File: tb/sim_aud_serial_tx.sv
`timescale 1ns/1ps
module sim_aud_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic [1:0]  cfg_wlen = 2'd0;
  logic        cfg_bclk_inv = 1'b0;
  logic        bclk_i = 1'b1;
  logic        wclk_i = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_left = '0;
  logic [31:0] smp_right = '0;
  logic        smp_ready, sdata_o, underrun_o;

  always #5 clk = ~clk;

  aud_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .cfg_bclk_inv(cfg_bclk_inv), .bclk_i(bclk_i), .wclk_i(wclk_i),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
    .smp_right(smp_right), .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    exp_bit [0:511];
  bit    w_arr   [0:511];
  logic [31:0] pl [0:3];
  logic [31:0] pr [0:3];
  bit    cur_exp;
  bit    exp_ur;
  int    cur_slot;
  string cur_tag;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s slot=%0d actual=%0h expected=%0h", req, cur_slot, act, exp);
    end
  endtask

  // one system clock: output must hold the expected bit of the current slot
  task automatic tick_chk();
    @(negedge clk);
    chk(cur_tag, {31'd0, sdata_o}, {31'd0, cur_exp});
    chk("R10 underrun", {31'd0, underrun_o}, {31'd0, exp_ur});
  endtask

  task automatic push(input int idx);
    chk("R9 ready before push", {31'd0, smp_ready}, 32'd1);
    smp_valid = 1'b1;
    smp_left  = pl[idx];
    smp_right = pr[idx];
    tick_chk();
    smp_valid = 1'b0;
    chk("R9 ready after push", {31'd0, smp_ready}, 32'd0);
  endtask

  task automatic place(input int st, input logic [31:0] v, input int wl);
    for (int i = 0; i < wl; i++) exp_bit[st + i] = v[wl - 1 - i];
  endtask

  // fmt: 0 LJ 1 RJ 2 I2S 3 DSPA 4 DSPB; pmask bit k: push during frame k
  task automatic run_seg(input int fmt, input int wlc, input int hh, input bit pol,
                         input int pw, input bit [1:0] pmask, input string tag);
    int wl, nsl, ur_slot, offl, offr, use_idx, base;
    bit rej, dsp, llev, lvl_l;
    wl  = (wlc == 0) ? 16 : (wlc == 1) ? 20 : (wlc == 2) ? 24 : 32;
    rej = (fmt == 1) && (wl == 32);
    dsp = (fmt >= 3);
    llev = (fmt == 2) ? 1'b0 : 1'b1;
    case (fmt)
      0: begin offl = 0;       offr = hh; end
      1: begin offl = hh - wl; offr = 2 * hh - wl; end
      2: begin offl = 1;       offr = hh + 1; end
      3: begin offl = 1;       offr = 1 + wl; end
      default: begin offl = 0; offr = wl; end
    endcase
    nsl = 7 * hh + 4;
    for (int s = 0; s < nsl; s++) begin
      exp_bit[s] = 1'b0;
      w_arr[s]   = dsp ? 1'b0 : ~llev;
    end
    for (int k = 0; k < 3; k++) begin
      base = hh + 2 * hh * k;
      for (int s = 0; s < 2 * hh; s++)
        w_arr[base + s] = dsp ? (s < pw) : ((s < hh) ? llev : ~llev);
    end
    for (int i = 0; i < 4; i++) begin
      pl[i] = $urandom;
      pr[i] = $urandom;
    end
    use_idx = 0;
    ur_slot = -1;
    for (int k = 0; k < 3; k++) begin
      base = hh + 2 * hh * k;
      if (k > 0) begin
        if (pmask[k - 1]) use_idx = k;
        else if (!rej && ur_slot < 0) ur_slot = base + offl;
      end
      if (!rej) begin
        place(base + offl, pl[use_idx], wl);
        place(base + offr, pr[use_idx], wl);
      end
    end
    // reset with the configuration applied (R11)
    lvl_l        = pol;
    rst_n        = 1'b0;
    cfg_fmt      = fmt[2:0];
    cfg_wlen     = wlc[1:0];
    cfg_bclk_inv = pol;
    bclk_i       = ~lvl_l;
    wclk_i       = w_arr[0];
    smp_valid    = 1'b0;
    cur_slot = -1;
    cur_exp  = 1'b0;
    exp_ur   = 1'b0;
    cur_tag  = tag;
    repeat (3) @(negedge clk);
    chk("R11 sdata in reset", {31'd0, sdata_o}, 32'd0);
    chk("R11 ready in reset", {31'd0, smp_ready}, 32'd1);
    chk("R11 underrun in reset", {31'd0, underrun_o}, 32'd0);
    rst_n = 1'b1;
    tick_chk();
    chk("R11 ready after reset", {31'd0, smp_ready}, 32'd1);
    push(0);
    for (int s = 0; s < nsl; s++) begin
      for (int k = 0; k < 2; k++)
        if (pmask[k] && s == hh + 2 * hh * k + hh) push(k + 1);
      bclk_i   = lvl_l;          // launch edge (R1)
      wclk_i   = w_arr[s];
      cur_slot = s;
      cur_exp  = exp_bit[s];
      exp_ur   = (ur_slot >= 0) && (s >= ur_slot);
      tick_chk();
      tick_chk();
      bclk_i = ~lvl_l;           // capture edge: no output change (R1)
      tick_chk();
      tick_chk();
    end
    if (rej) chk("R5 rejected mode keeps sample held", {31'd0, smp_ready}, 32'd0);
  endtask

  initial begin
    run_seg(0, 0, 16, 1'b0, 1, 2'b11, "R3 R8 R1 sdata");
    run_seg(2, 0, 16, 1'b1, 1, 2'b11, "R4 R1 R2 sdata");
    run_seg(1, 1, 24, 1'b0, 1, 2'b11, "R5 R2 R8 sdata");
    run_seg(3, 0, 16, 1'b0, 1, 2'b11, "R6 R8 sdata");
    run_seg(4, 2, 28, 1'b1, 3, 2'b10, "R7 R10 sdata");
    run_seg(1, 3, 32, 1'b0, 1, 2'b00, "R5 rejected sdata");
    run_seg(0, 3, 32, 1'b1, 1, 2'b01, "R2 R10 sdata");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule